// File: doc/BRIEF.md
# EDO DRAM Access Sequencer

This block sits between a byte-wide request port and one extended-data-out DRAM device of 8M x 8. Each request carries a flat address, a direction bit and, for writes, a data byte. The block splits the address into a row part and a column part. It multiplexes them onto a shared address bus and produces the active-low row strobe, column strobe, write enable and output enable. For writes it drives the data bus and its enable. For reads it captures the returned byte and reports it with a one-cycle valid pulse.

A row stays open after an access, so that later requests to the same row need only a new column strobe. A request to another row closes the open row, waits out the precharge time and then opens the new row. The row-low time is budgeted: the row is closed early whenever another column access would not fit in the limit. A separate refresh arbiter asks for the device through a request line. The sequencer closes any open row, waits out precharge and then grants the device until the arbiter lets go.

Every timing value is a parameter counted in clock cycles. The row and column widths are parameters, so both the 13+10 and the 12+11 address splits are supported.

Top module: `edo_seq`

## Requirements
- R1: After reset, all four strobes are high, the data bus enable is low, `rd_valid` and `ref_gnt` are low, and `req_ready` is high.
- R2: On a row miss, the row strobe falls with the row address (`req_addr[ADDR_W-1:COL_W]`) on the bus. The column strobe falls exactly T_RCD+1 cycles later, with the column address (`req_addr[COL_W-1:0]`) on the bus. The column strobe is never low while the row strobe is high.
- R3: Every column strobe pulse is low for exactly T_CAS cycles. It stays high for at least T_CP cycles before the next pulse in the same row.
- R4: For a write, the write enable is low and the data bus is driven with the request byte from at least one cycle before the column strobe falls until it rises. The output enable stays high whenever the write enable is low, and the data bus is driven only while the write enable is low.
- R5: For a read, the write enable stays high, the data bus is not driven, and the output enable is low while the column strobe is low. The byte present in the last column-low cycle is returned on `rd_data`, with `rd_valid` high for one cycle, in the cycle in which the column strobe rises.
- R6: A request to the row that is already open is served with a new column strobe and no new row strobe fall.
- R7: The row strobe is high for at least T_RP cycles before every fall, including after a row miss and after a refresh grant ends.
- R8: The row strobe is never low for more than T_RAS_MAX consecutive cycles. An open row left idle is closed by itself.
- R9: `ref_gnt` rises only while both strobes are high and the row strobe has been high for at least T_RP cycles. No request is accepted while `ref_req` or `ref_gnt` is high. `ref_gnt` falls one cycle after `ref_req` falls.
- R10: A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` is low while the column strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Flat byte address, row in the upper bits |
| req_wdata | input | DATA_W | Write byte |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | DATA_W | Read byte |
| ref_req | input | 1 | Refresh arbiter wants the device |
| ref_gnt | output | 1 | Device handed to the refresh arbiter |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_oe | output | 1 | Drive enable for the data bus |
| dram_dq_out | output | DATA_W | Data driven to the device |
| dram_dq_in | input | DATA_W | Data returned by the device |

## Verification
The assertions assume three things about the inputs. A requester keeps `req_valid` and its address and data stable until the request is taken. The refresh arbiter holds `ref_req` until it has used its grant. The timing parameters leave room for one full miss access inside T_RAS_MAX. The bench drives requests only at falling clock edges and holds them through acceptance. Its memory model returns a byte only while both strobes and the output enable are low with the write enable high. A read that samples outside the column-low window therefore returns zero rather than the stored byte.

// File: rtl/edo_seq_pkg.sv
package edo_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRECH,
        ST_ROWACT,
        ST_COLSET,
        ST_COLACT,
        ST_CASPRE,
        ST_OPEN,
        ST_REF
    } edo_state_e;

endpackage

// File: rtl/edo_addr_split.sv
module edo_addr_split #(
    parameter int ROW_W = 13,
    parameter int COL_W = 10,
    parameter int BUS_W = 13
) (
    input  logic [ROW_W+COL_W-1:0] addr,
    input  logic                   row_open,
    input  logic [ROW_W-1:0]       open_row,
    output logic [ROW_W-1:0]       row_of,
    output logic [BUS_W-1:0]       row_bus,
    output logic [BUS_W-1:0]       col_bus,
    output logic                   hit
);
    logic [COL_W-1:0] col_of;

    assign row_of = addr[ROW_W+COL_W-1:COL_W];
    assign col_of = addr[COL_W-1:0];
    assign hit    = row_open && (row_of == open_row);

    // pad the narrower half up to the shared bus width
    generate
        if (BUS_W == ROW_W) begin : g_row_full
            assign row_bus = row_of;
        end else begin : g_row_pad
            assign row_bus = {{(BUS_W-ROW_W){1'b0}}, row_of};
        end
        if (BUS_W == COL_W) begin : g_col_full
            assign col_bus = col_of;
        end else begin : g_col_pad
            assign col_bus = {{(BUS_W-COL_W){1'b0}}, col_of};
        end
    endgenerate
endmodule

// File: rtl/edo_ras_guard.sv
module edo_ras_guard #(
    parameter int T_RAS_MAX = 40,
    parameter int ACC_LEN   = 4,
    parameter int T_RP      = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    output logic room
);
    localparam int CW = $clog2(T_RAS_MAX + 2);
    localparam int HW = $clog2(T_RP + 2);

    logic [CW-1:0] lo_d, lo_q;   // cycles the row strobe has been low before now
    logic [HW-1:0] hi_d, hi_q;   // cycles the row strobe has been high, saturating

    always_comb begin
        lo_d = lo_q;
        hi_d = hi_q;
        if (ras_n) begin
            lo_d = '0;
            if (hi_q != HW'(T_RP)) hi_d = hi_q + 1'b1;
        end else begin
            hi_d = '0;
            if (lo_q != CW'(T_RAS_MAX + 1)) lo_d = lo_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= HW'(T_RP);
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    // another column access plus the closing cycle must still fit
    assign room = ras_n || ((32'(lo_q) + 32'(ACC_LEN) + 32'd2) <= 32'(T_RAS_MAX));

    p_ras_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (32'(lo_q) < 32'(T_RAS_MAX)));

    p_precharge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (32'(hi_q) >= 32'(T_RP)));
endmodule

// File: rtl/edo_seq.sv
module edo_seq
    import edo_seq_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int DATA_W    = 8,
    parameter int T_RCD     = 3,
    parameter int T_CAS     = 2,
    parameter int T_CP      = 1,
    parameter int T_RP      = 3,
    parameter int T_RAS_MAX = 40,
    localparam int ADDR_W   = ROW_W + COL_W,
    localparam int BUS_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ref_req,
    output logic              ref_gnt,
    output logic [BUS_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic              dram_dq_oe,
    output logic [DATA_W-1:0] dram_dq_out,
    input  logic [DATA_W-1:0] dram_dq_in
);
    localparam int ACC_LEN = 1 + T_CAS + T_CP;
    localparam int TM_A    = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int TM_B    = (T_CP > T_RP) ? T_CP : T_RP;
    localparam int TMAX    = (TM_A > TM_B) ? TM_A : TM_B;
    localparam int TMR_W   = $clog2(TMAX + 1);

    typedef struct packed {
        edo_state_e        st;
        logic [TMR_W-1:0]  tmr;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic [BUS_W-1:0]  bus;
        logic [ROW_W-1:0]  row;
        logic [BUS_W-1:0]  col;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rd_valid;
        logic              gnt;
    } seq_t;

    seq_t q, n;
    logic ready;

    logic [ROW_W-1:0] row_of;
    logic [BUS_W-1:0] row_bus;
    logic [BUS_W-1:0] col_bus;
    logic             hit;
    logic             room;

    edo_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W), .BUS_W(BUS_W)) u_split (
        .addr     (req_addr),
        .row_open (q.st == ST_OPEN),
        .open_row (q.row),
        .row_of   (row_of),
        .row_bus  (row_bus),
        .col_bus  (col_bus),
        .hit      (hit)
    );

    edo_ras_guard #(.T_RAS_MAX(T_RAS_MAX), .ACC_LEN(ACC_LEN), .T_RP(T_RP)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .ras_n (q.ras_n),
        .room  (room)
    );

    always_comb begin
        n          = q;
        n.rd_valid = 1'b0;
        ready      = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (ref_req) begin
                    n.st  = ST_REF;
                    n.gnt = 1'b1;
                end else begin
                    ready = 1'b1;
                    if (req_valid) begin
                        n.st    = ST_ROWACT;
                        n.ras_n = 1'b0;
                        n.bus   = row_bus;
                        n.row   = row_of;
                        n.col   = col_bus;
                        n.wr    = req_write;
                        n.wdata = req_wdata;
                        n.tmr   = TMR_W'(T_RCD - 1);
                    end
                end
            end
            ST_ROWACT: begin
                if (q.tmr != '0) begin
                    n.tmr = q.tmr - 1'b1;
                end else begin
                    n.st    = ST_COLSET;
                    n.bus   = q.col;
                    n.we_n  = !q.wr;
                    n.dq_oe = q.wr;
                end
            end
            ST_COLSET: begin
                n.st    = ST_COLACT;
                n.cas_n = 1'b0;
                n.oe_n  = q.wr;
                n.tmr   = TMR_W'(T_CAS - 1);
            end
            ST_COLACT: begin
                if (q.tmr != '0) begin
                    n.tmr = q.tmr - 1'b1;
                end else begin
                    n.st       = ST_CASPRE;
                    n.cas_n    = 1'b1;
                    n.oe_n     = 1'b1;
                    n.we_n     = 1'b1;
                    n.dq_oe    = 1'b0;
                    n.rd_valid = !q.wr;
                    if (!q.wr) n.rdata = dram_dq_in;
                    n.tmr      = TMR_W'(T_CP - 1);
                end
            end
            ST_CASPRE: begin
                if (q.tmr != '0) n.tmr = q.tmr - 1'b1;
                else             n.st  = ST_OPEN;
            end
            ST_OPEN: begin
                if (ref_req || !room || (req_valid && !hit)) begin
                    n.st    = ST_PRECH;
                    n.ras_n = 1'b1;
                    n.tmr   = TMR_W'(T_RP - 1);
                end else begin
                    ready = 1'b1;
                    if (req_valid) begin
                        n.st    = ST_COLSET;
                        n.bus   = col_bus;
                        n.col   = col_bus;
                        n.wr    = req_write;
                        n.wdata = req_wdata;
                        n.we_n  = !req_write;
                        n.dq_oe = req_write;
                    end
                end
            end
            ST_PRECH: begin
                if (q.tmr != '0) n.tmr = q.tmr - 1'b1;
                else             n.st  = ST_IDLE;
            end
            ST_REF: begin
                if (!ref_req) begin
                    n.gnt = 1'b0;
                    n.st  = ST_PRECH;
                    n.tmr = TMR_W'(T_RP - 1);
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
            q.ras_n    <= 1'b1;
            q.cas_n    <= 1'b1;
            q.we_n     <= 1'b1;
            q.oe_n     <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign req_ready   = ready;
    assign rd_valid    = q.rd_valid;
    assign rd_data     = q.rdata;
    assign ref_gnt     = q.gnt;
    assign dram_addr   = q.bus;
    assign dram_ras_n  = q.ras_n;
    assign dram_cas_n  = q.cas_n;
    assign dram_we_n   = q.we_n;
    assign dram_oe_n   = q.oe_n;
    assign dram_dq_oe  = q.dq_oe;
    assign dram_dq_out = q.wdata;

    p_cas_in_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    p_we_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n && dram_dq_oe));

    p_write_no_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> dram_oe_n);

    p_drive_only_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> !dram_we_n);

    p_rdv_at_cas_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($rose(dram_cas_n) && dram_we_n));

    p_gnt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt |-> (dram_ras_n && dram_cas_n));

    p_gnt_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_gnt && !ref_req) |=> !ref_gnt);

    p_no_take_in_ref_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req || ref_gnt) |-> !req_ready);

    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !req_ready);
endmodule

// File: tb/edo_seq_test.sv
module edo_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_W = 13;
    localparam int COL_W = 10;
    localparam int DW    = 8;
    localparam int AW    = ROW_W + COL_W;
    localparam int BW    = 13;
    localparam int T_RCD = 3;
    localparam int T_CAS = 2;
    localparam int T_CP  = 1;
    localparam int T_RP  = 3;
    localparam int T_RAS_MAX = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic ref_req = 1'b0;
    logic req_ready, rd_valid, ref_gnt;
    logic [DW-1:0] rd_data;
    logic [BW-1:0] dram_addr;
    logic dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [DW-1:0] dram_dq_out, dram_dq_in;

    always #(CLK_PERIOD/2) clk = ~clk;

    edo_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW), .T_RCD(T_RCD), .T_CAS(T_CAS),
              .T_CP(T_CP), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_oe(dram_dq_oe),
        .dram_dq_out(dram_dq_out), .dram_dq_in(dram_dq_in)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- memory model and protocol monitor ----------------
    logic [DW-1:0] mem [int];
    logic [DW-1:0] rd_lat = '0;
    logic [ROW_W-1:0] row_lat = '0;
    int cur_row = 0;
    int cur_col = 0;

    function automatic logic [DW-1:0] dflt(input int key);
        return key[7:0] ^ 8'h5A;
    endfunction

    assign dram_dq_in = (!dram_ras_n && !dram_cas_n && !dram_oe_n && dram_we_n) ? rd_lat : '0;

    int  cyc = 0;
    bit  p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, p_gnt = 1'b0, p_dqoe = 1'b0;
    int  hi_run = 100, lo_run = 0, ras_fall_cyc = 0, cas_fall_cyc = 0, cas_rise_cyc = -100;
    bit  first_cas = 1'b0;
    int  opens = 0, cas_falls = 0, cas_rises = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!dram_ras_n) lo_run++;
            if (dram_ras_n) hi_run++;
            if (p_ras && !dram_ras_n) begin
                opens++;
                chk(hi_run >= T_RP, "R7", "row high cycles before fall", hi_run, T_RP);
                chk(int'(dram_addr) == cur_row, "R2", "row address at row fall", dram_addr, cur_row);
                row_lat = dram_addr[ROW_W-1:0];
                ras_fall_cyc = cyc;
                first_cas = 1'b1;
                hi_run = 0;
                lo_run = 1;
            end
            if (!p_ras && dram_ras_n) begin
                chk(lo_run - 1 <= T_RAS_MAX, "R8", "row low run", lo_run - 1, T_RAS_MAX);
                hi_run = 1;
            end
            if (!dram_cas_n) begin
                chk(!dram_ras_n, "R2", "column low inside row", dram_ras_n, 0);
                chk(!req_ready, "R10", "ready while column low", req_ready, 0);
            end
            if (p_cas && !dram_cas_n) begin
                int key;
                cas_falls++;
                if (first_cas)
                    chk(cyc - ras_fall_cyc == T_RCD + 1, "R2", "row-to-column cycles",
                        cyc - ras_fall_cyc, T_RCD + 1);
                else
                    chk(cyc - cas_rise_cyc >= T_CP, "R3", "column high gap",
                        cyc - cas_rise_cyc, T_CP);
                first_cas = 1'b0;
                chk(int'(dram_addr) == cur_col, "R2", "column address at column fall",
                    dram_addr, cur_col);
                key = int'({row_lat, dram_addr[COL_W-1:0]});
                if (!dram_we_n) begin
                    chk(!p_we && p_dqoe, "R4", "write enable set up before column fall", p_we, 0);
                    chk(dram_oe_n, "R4", "output enable during write", dram_oe_n, 1);
                    mem[key] = dram_dq_out;
                end else begin
                    chk(!dram_oe_n && !dram_dq_oe, "R5", "read enables", {dram_oe_n, dram_dq_oe}, 0);
                    rd_lat = mem.exists(key) ? mem[key] : dflt(key);
                end
                cas_fall_cyc = cyc;
            end
            if (!p_cas && dram_cas_n) begin
                cas_rises++;
                chk(cyc - cas_fall_cyc == T_CAS, "R3", "column low width", cyc - cas_fall_cyc, T_CAS);
                cas_rise_cyc = cyc;
            end
            if (dram_dq_oe)
                chk(!dram_we_n, "R4", "bus driven only in write", dram_we_n, 0);
            if (!p_gnt && ref_gnt) begin
                chk(dram_ras_n && dram_cas_n, "R9", "strobes high at grant", {dram_ras_n, dram_cas_n}, 3);
                chk(hi_run >= T_RP, "R9", "precharge before grant", hi_run, T_RP);
            end
            p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n;
            p_gnt = ref_gnt; p_dqoe = dram_dq_oe;
        end
    end

    // ---------------- request driver ----------------
    task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output logic [DW-1:0] got, output bit got_v);
        int rises0;
        bit taken;
        got = '0;
        got_v = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        cur_row = int'(a[AW-1:COL_W]);
        cur_col = int'(a[COL_W-1:0]);
        rises0 = cas_rises;
        taken = 1'b0;
        for (int i = 0; i < 200 && !taken; i++) begin
            #1;
            taken = req_ready;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(taken, "R10", "request taken", taken, 1);
        for (int i = 0; i < 200 && cas_rises == rises0; i++) begin
            #1;
            if (rd_valid) begin got = rd_data; got_v = 1'b1; end
            if (cas_rises == rises0) @(negedge clk);
        end
        #1;
        if (rd_valid) begin got = rd_data; got_v = 1'b1; end
        @(negedge clk);
        #1;
        chk(!rd_valid, "R5", "valid is a single pulse", rd_valid, 0);
    endtask

    // {write, expect_open, row, col, data}
    localparam int NV = 12;
    localparam logic [32:0] VEC [NV] = '{
        {1'b1, 1'b1, 13'd5,    10'd3,    8'hA1},
        {1'b1, 1'b0, 13'd5,    10'd4,    8'hB2},
        {1'b0, 1'b0, 13'd5,    10'd3,    8'h00},
        {1'b0, 1'b0, 13'd5,    10'd4,    8'h00},
        {1'b1, 1'b1, 13'd9,    10'd3,    8'hC3},
        {1'b0, 1'b1, 13'd5,    10'd3,    8'h00},
        {1'b0, 1'b1, 13'd9,    10'd3,    8'h00},
        {1'b1, 1'b0, 13'd9,    10'd1023, 8'hD4},
        {1'b0, 1'b0, 13'd9,    10'd1023, 8'h00},
        {1'b0, 1'b1, 13'd8191, 10'd0,    8'h00},
        {1'b1, 1'b1, 13'd0,    10'd0,    8'hE5},
        {1'b0, 1'b0, 13'd0,    10'd0,    8'h00}
    };

    logic [DW-1:0] shadow [int];

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] got;
        bit got_v;
        int o0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1", "strobes after reset",
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
        chk(!dram_dq_oe && !rd_valid && !ref_gnt, "R1", "enables after reset",
            {dram_dq_oe, rd_valid, ref_gnt}, 0);
        chk(req_ready, "R1", "ready after reset", req_ready, 1);

        // table walk: R2..R7 data path and row reuse
        for (int v = 0; v < NV; v++) begin
            logic [AW-1:0] a;
            int key;
            logic [DW-1:0] exp;
            a = {VEC[v][30:18], VEC[v][17:8]};
            key = int'(a);
            o0 = opens;
            do_req(VEC[v][32], a, VEC[v][7:0], got, got_v);
            if (VEC[v][32]) begin
                shadow[key] = VEC[v][7:0];
            end else begin
                exp = shadow.exists(key) ? shadow[key] : dflt(key);
                chk(got_v, "R5", "read valid pulse", got_v, 1);
                chk(got == exp, "R5", "read data", got, exp);
            end
            chk((opens - o0) == int'(VEC[v][31]), VEC[v][31] ? "R7" : "R6",
                "row opens for request", opens - o0, VEC[v][31]);
        end

        // R8: a long run of hits must be split by the row budget
        o0 = opens;
        for (int i = 0; i < 10; i++) begin
            do_req(1'b0, {13'd3, 10'(i)}, 8'h00, got, got_v);
            chk(got == dflt(int'({13'd3, 10'(i)})), "R8", "read during long page", got,
                dflt(int'({13'd3, 10'(i)})));
        end
        chk(opens - o0 >= 2, "R8", "row reopened after budget", opens - o0, 2);

        // R8: an idle open row closes by itself
        do_req(1'b1, {13'd4, 10'd7}, 8'h6C, got, got_v);
        repeat (T_RAS_MAX + 5) @(negedge clk);
        #1;
        chk(dram_ras_n, "R8", "idle row closed", dram_ras_n, 1);

        // R9: refresh taken from an open row while a hit is pending
        do_req(1'b0, {13'd4, 10'd7}, 8'h00, got, got_v);
        chk(got == 8'h6C, "R9", "read before refresh", got, 8'h6C);
        begin
            int f0;
            bit saw;
            f0 = cas_falls;
            @(negedge clk);
            ref_req = 1'b1;
            req_valid = 1'b1; req_write = 1'b0; req_addr = {13'd4, 10'd7};
            saw = 1'b0;
            for (int i = 0; i < 50 && !saw; i++) begin
                @(negedge clk);
                #1;
                saw = ref_gnt;
            end
            chk(saw, "R9", "grant given", saw, 1);
            repeat (5) begin
                @(negedge clk);
                #1;
                chk(!req_ready && ref_gnt, "R9", "held off while granted", {req_ready, ref_gnt}, 1);
            end
            chk(cas_falls == f0, "R9", "no column access during refresh", cas_falls - f0, 0);
            req_valid = 1'b0;
            ref_req = 1'b0;
            @(negedge clk);
            #1;
            chk(!ref_gnt, "R9", "grant released", ref_gnt, 0);
        end
        o0 = opens;
        do_req(1'b0, {13'd4, 10'd7}, 8'h00, got, got_v);
        chk(got == 8'h6C, "R9", "read after refresh", got, 8'h6C);
        chk(opens - o0 == 1, "R9", "row reopened after refresh", opens - o0, 1);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule